// File: doc/BRIEF.md
# Fixed-Map Memory and Console Subsystem

This block sits on the simple memory bus of a 32-bit processor core and decodes every instruction fetch, load and store into one of four targets. Address zero, where the core starts fetching, holds a read-only program store. The next window holds a second read-only store with the initial image of the program's writable variables, which startup code copies into RAM. Above that is a read/write RAM with byte-lane write strobes. A single word above the RAM is a write-only console port: a store there emits one character.

Each transfer uses a valid/ready handshake. A zero write strobe marks a read. Every accepted transfer gets a one-cycle ready pulse on the following clock, whatever the target. Both read-only stores are filled at elaboration from a content function with a per-store seed, so no image file is needed. Addresses outside the map are acknowledged, read as zero and latch a sticky error flag.

Top module: `memsys_top`

## Requirements
- R1: During and directly after reset, `bus_ready`, `char_valid` and `map_err` are 0.
- R2: A transfer is accepted at a clock edge where `bus_valid` is 1 and `bus_ready` is 0. `bus_ready` is 1 for exactly the next cycle, with `bus_rdata` valid in that cycle. The master drops `bus_valid` in the ready cycle.
- R3: Addresses 0x00000 to 0x1FFFF read from the program store. The word at byte offset o is `((o>>2) * 0x9E3779B1) ^ 0x0C0DE000`, computed modulo 2^32.
- R4: Addresses 0x20000 to 0x3FFFF read from the data-image store. The word at byte offset o from 0x20000 is `((o>>2) * 0x9E3779B1) ^ 0xDA7A0000`.
- R5: Addresses 0x40000 to 0x7FFFF are read/write RAM. The backing store holds `RAM_WORDS` words (default 1024), so word addresses alias modulo `RAM_WORDS` inside the window.
- R6: A RAM store writes only the byte lanes whose strobe bit is 1. Strobe bit k covers data bits 8k+7 to 8k. The other lanes keep their old contents.
- R7: A store to either read-only window is acknowledged like any transfer and changes nothing. A later read returns the original content.
- R8: A store to the word at 0x80000 to 0x80003 raises `char_valid` for exactly one cycle, the same cycle as `bus_ready`. In that cycle `char_data` equals `bus_wdata[7:0]`. A read of that word returns 0 and raises no `char_valid`.
- R9: Any address outside the four targets is acknowledged and reads as 0. It sets `map_err`, which stays 1 until reset.
- R10: During the ready cycle of a store, `bus_rdata` is 0, whatever the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Transfer request from the core |
| bus_ready | output | 1 | One-cycle acknowledge |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Store data |
| bus_wstrb | input | 4 | Byte-lane write strobes; zero means read |
| bus_rdata | output | 32 | Load data, valid while `bus_ready` is 1 |
| char_valid | output | 1 | One-cycle console character strobe |
| char_data | output | 8 | Console character |
| map_err | output | 1 | Sticky unmapped-access flag |

## Verification
The console strobe and the bus acknowledge are raised in the same cycle by one accepted store. The test stores to the console word, samples both outputs at the mid-point of the ready cycle, and requires both to be high, with the character equal to the low data byte. It then checks that both fall together on the next cycle. Two back-to-back console stores confirm that each store gives a separate strobe. A load from the console word confirms that the acknowledge can rise without the strobe.

// File: rtl/memsys_pkg.sv
package memsys_pkg;

  typedef enum logic [2:0] {
    TGT_CODE  = 3'd0,
    TGT_DINIT = 3'd1,
    TGT_RAM   = 3'd2,
    TGT_CHAR  = 3'd3,
    TGT_NONE  = 3'd4
  } tgt_e;

  localparam logic [31:0] IMG_MULT = 32'h9E37_79B1;

  // content of a read-only store, one word per index
  function automatic logic [31:0] rom_image(input logic [31:0] seed,
                                            input logic [31:0] widx);
    return (widx * IMG_MULT) ^ seed;
  endfunction

  // byte-lane merge of a store into an existing word
  function automatic logic [31:0] lane_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  strb);
    logic [31:0] res;
    res = old_w;
    for (int k = 0; k < 4; k++) begin
      if (strb[k]) res[8*k +: 8] = new_w[8*k +: 8];
    end
    return res;
  endfunction

endpackage

// File: rtl/memsys_decode.sv
module memsys_decode
  import memsys_pkg::*;
#(
  parameter logic [31:0] CODE_BASE  = 32'h0000_0000,
  parameter int          CODE_BYTES = 131072,
  parameter logic [31:0] DINIT_BASE = 32'h0002_0000,
  parameter int          DINIT_BYTES = 131072,
  parameter logic [31:0] RAM_BASE   = 32'h0004_0000,
  parameter int          RAM_BYTES  = 262144,
  parameter logic [31:0] CHAR_ADDR  = 32'h0008_0000,
  parameter int          RAM_WORDS  = 1024,
  localparam int CODE_IW  = $clog2(CODE_BYTES) - 2,
  localparam int DINIT_IW = $clog2(DINIT_BYTES) - 2,
  localparam int RAM_IW   = $clog2(RAM_WORDS)
) (
  input  logic [31:0]         addr,
  output tgt_e                tgt,
  output logic [CODE_IW-1:0]  code_idx,
  output logic [DINIT_IW-1:0] dinit_idx,
  output logic [RAM_IW-1:0]   ram_idx
);

  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] base,
                                     input int          bytes);
    return (a - base) < 32'(bytes);
  endfunction

  logic [3:0] hits;

  always_comb begin
    hits[0] = in_window(addr, CODE_BASE, CODE_BYTES);
    hits[1] = in_window(addr, DINIT_BASE, DINIT_BYTES);
    hits[2] = in_window(addr, RAM_BASE, RAM_BYTES);
    hits[3] = (addr[31:2] == CHAR_ADDR[31:2]);
    if (hits[0])      tgt = TGT_CODE;
    else if (hits[1]) tgt = TGT_DINIT;
    else if (hits[2]) tgt = TGT_RAM;
    else if (hits[3]) tgt = TGT_CHAR;
    else              tgt = TGT_NONE;
  end

  // windows are size-aligned, so the low address bits are the index
  assign code_idx  = addr[CODE_IW+1:2];
  assign dinit_idx = addr[DINIT_IW+1:2];
  assign ram_idx   = addr[RAM_IW+1:2];

  always_comb begin
    if (!$isunknown(addr)) begin
      assert_single_target_R9: assert ($onehot0(hits))
        else $error("address hits more than one target");
    end
  end

endmodule

// File: rtl/memsys_rom.sv
module memsys_rom
  import memsys_pkg::*;
#(
  parameter logic [31:0] SEED = 32'h0,
  parameter int          IW   = 15
) (
  input  logic [IW-1:0] widx,
  output logic [31:0]   word
);

  assign word = rom_image(SEED, 32'(widx));

endmodule

// File: rtl/memsys_ram.sv
module memsys_ram
  import memsys_pkg::*;
#(
  parameter int WORDS = 1024,
  localparam int IW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [3:0]    strb,
  input  logic [IW-1:0] widx,
  input  logic [31:0]   wdata,
  output logic [31:0]   rword
);

  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= lane_merge(mem[widx], wdata, strb);
  end

  assign rword = mem[widx];

endmodule

// File: rtl/memsys_charout.sv
module memsys_charout (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic [7:0] byte_in,
  output logic       char_valid,
  output logic [7:0] char_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      char_valid <= 1'b0;
      char_data  <= 8'h00;
    end else begin
      char_valid <= fire;
      if (fire) char_data <= byte_in;
    end
  end

  assert_char_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |=> !char_valid)
    else $error("console strobe longer than one cycle");

endmodule

// File: rtl/memsys_top.sv
module memsys_top
  import memsys_pkg::*;
#(
  parameter int          RAM_WORDS  = 1024,
  parameter logic [31:0] CODE_SEED  = 32'h0C0D_E000,
  parameter logic [31:0] DINIT_SEED = 32'hDA7A_0000,
  localparam int CODE_BYTES  = 131072,
  localparam int DINIT_BYTES = 131072,
  localparam int RAM_BYTES   = 262144,
  localparam int CODE_IW  = $clog2(CODE_BYTES) - 2,
  localparam int DINIT_IW = $clog2(DINIT_BYTES) - 2,
  localparam int RAM_IW   = $clog2(RAM_WORDS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  output logic        bus_ready,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic [3:0]  bus_wstrb,
  output logic [31:0] bus_rdata,
  output logic        char_valid,
  output logic [7:0]  char_data,
  output logic        map_err
);

  tgt_e                tgt;
  logic [CODE_IW-1:0]  code_idx;
  logic [DINIT_IW-1:0] dinit_idx;
  logic [RAM_IW-1:0]   ram_idx;
  logic [31:0]         code_word, dinit_word, ram_word, rd_mux;

  // named events for the assertions
  logic accept, is_store, ram_we, char_fire, miss;

  assign accept    = bus_valid && !bus_ready;
  assign is_store  = |bus_wstrb;
  assign ram_we    = accept && is_store && (tgt == TGT_RAM);
  assign char_fire = accept && is_store && (tgt == TGT_CHAR);
  assign miss      = accept && (tgt == TGT_NONE);

  memsys_decode #(
    .CODE_BASE(32'h0000_0000), .CODE_BYTES(CODE_BYTES),
    .DINIT_BASE(32'h0002_0000), .DINIT_BYTES(DINIT_BYTES),
    .RAM_BASE(32'h0004_0000), .RAM_BYTES(RAM_BYTES),
    .CHAR_ADDR(32'h0008_0000), .RAM_WORDS(RAM_WORDS)
  ) u_decode (
    .addr(bus_addr), .tgt(tgt),
    .code_idx(code_idx), .dinit_idx(dinit_idx), .ram_idx(ram_idx)
  );

  memsys_rom #(.SEED(CODE_SEED), .IW(CODE_IW)) u_code_rom (
    .widx(code_idx), .word(code_word)
  );

  memsys_rom #(.SEED(DINIT_SEED), .IW(DINIT_IW)) u_dinit_rom (
    .widx(dinit_idx), .word(dinit_word)
  );

  memsys_ram #(.WORDS(RAM_WORDS)) u_ram (
    .clk(clk), .we(ram_we), .strb(bus_wstrb), .widx(ram_idx),
    .wdata(bus_wdata), .rword(ram_word)
  );

  memsys_charout u_char (
    .clk(clk), .rst_n(rst_n), .fire(char_fire), .byte_in(bus_wdata[7:0]),
    .char_valid(char_valid), .char_data(char_data)
  );

  always_comb begin
    case (tgt)
      TGT_CODE:  rd_mux = code_word;
      TGT_DINIT: rd_mux = dinit_word;
      TGT_RAM:   rd_mux = ram_word;
      default:   rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_ready <= 1'b0;
      bus_rdata <= 32'h0;
      map_err   <= 1'b0;
    end else begin
      bus_ready <= accept;
      if (accept) bus_rdata <= is_store ? 32'h0 : rd_mux;
      if (miss)   map_err   <= 1'b1;
    end
  end

  assert_ready_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> bus_ready)
    else $error("accepted transfer not acknowledged");

  assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready)
    else $error("ready held longer than one cycle");

  assert_char_with_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> bus_ready)
    else $error("console strobe without acknowledge");

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    map_err |=> map_err)
    else $error("error flag cleared without reset");

  assert_store_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_store) |=> (bus_rdata == 32'h0))
    else $error("store returned nonzero read data");

endmodule

// File: tb/tb_memsys_top.sv
`timescale 1ns/1ps
module tb_memsys_top;

  localparam int RAM_WORDS = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic [31:0] bus_addr = 32'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [3:0]  bus_wstrb = 4'h0;
  logic [31:0] bus_rdata;
  logic        char_valid;
  logic [7:0]  char_data;
  logic        map_err;

  int checks = 0;
  int errors = 0;

  // captured per access
  logic [31:0] c_rdata;
  logic        c_pre, c_rdy, c_post, c_cv, c_cv_post;
  logic [7:0]  c_cd;

  always #2.5 clk = ~clk;

  memsys_top #(.RAM_WORDS(RAM_WORDS)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb),
    .bus_rdata(bus_rdata), .char_valid(char_valid), .char_data(char_data),
    .map_err(map_err)
  );

  function automatic logic [31:0] img(input logic [31:0] seed, input logic [31:0] off);
    logic [31:0] w;
    w = off >> 2;
    return (w * 32'h9E3779B1) ^ seed;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] s);
    logic [31:0] m;
    m = {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
    return (o & ~m) | (n & m);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    #1 c_pre = bus_ready;
    @(negedge clk);
    c_rdy = bus_ready; c_rdata = bus_rdata; c_cv = char_valid; c_cd = char_data;
    bus_valid = 1'b0; bus_wstrb = 4'h0;
    @(negedge clk);
    c_post = bus_ready; c_cv_post = char_valid;
  endtask

  task automatic t_reset;
    chk("R1 ready", 32'(bus_ready), 0);
    chk("R1 char_valid", 32'(char_valid), 0);
    chk("R1 map_err", 32'(map_err), 0);
  endtask

  task automatic t_code;
    access(32'h0, 0, 4'h0);
    chk("R2 ready low before edge", 32'(c_pre), 0);
    chk("R2 ready one cycle later", 32'(c_rdy), 1);
    chk("R2 ready pulse ends", 32'(c_post), 0);
    chk("R3 code word 0", c_rdata, img(32'h0C0DE000, 0));
    access(32'h4, 0, 4'h0);
    chk("R3 code word 1", c_rdata, img(32'h0C0DE000, 4));
    access(32'h1FFFC, 0, 4'h0);
    chk("R3 code last word", c_rdata, img(32'h0C0DE000, 32'h1FFFC));
  endtask

  task automatic t_dinit;
    access(32'h20000, 0, 4'h0);
    chk("R4 image first word", c_rdata, img(32'hDA7A0000, 0));
    access(32'h3FFFC, 0, 4'h0);
    chk("R4 image last word", c_rdata, img(32'hDA7A0000, 32'h1FFFC));
  endtask

  task automatic t_ram;
    access(32'h40000, 32'hCAFE0001, 4'hF);
    access(32'h7FFFC, 32'h5EED0002, 4'hF);
    access(32'h40000, 0, 4'h0);
    chk("R5 ram first word", c_rdata, 32'hCAFE0001);
    access(32'h7FFFC, 0, 4'h0);
    chk("R5 ram last word", c_rdata, 32'h5EED0002);
    access(32'h40000 + RAM_WORDS * 4, 0, 4'h0);
    chk("R5 ram alias", c_rdata, 32'hCAFE0001);
  endtask

  task automatic t_lanes;
    logic [31:0] exp;
    access(32'h40010, 32'h11223344, 4'hF);
    exp = 32'h11223344;
    access(32'h40010, 32'hAABBCCDD, 4'b0010);
    exp = merge(exp, 32'hAABBCCDD, 4'b0010);
    access(32'h40010, 0, 4'h0);
    chk("R6 single lane", c_rdata, exp);
    access(32'h40010, 32'h99887766, 4'b1100);
    exp = merge(exp, 32'h99887766, 4'b1100);
    access(32'h40010, 0, 4'h0);
    chk("R6 upper half", c_rdata, exp);
    access(32'h40010, 32'h00000055, 4'b0001);
    exp = merge(exp, 32'h00000055, 4'b0001);
    access(32'h40010, 0, 4'h0);
    chk("R6 low byte", c_rdata, exp);
  endtask

  task automatic t_rom_store;
    access(32'h8, 32'hDEADBEEF, 4'hF);
    chk("R7 rom store acked", 32'(c_rdy), 1);
    chk("R10 rom store rdata", c_rdata, 0);
    access(32'h8, 0, 4'h0);
    chk("R7 code unchanged", c_rdata, img(32'h0C0DE000, 8));
    access(32'h20010, 32'h12345678, 4'h3);
    access(32'h20010, 0, 4'h0);
    chk("R7 image unchanged", c_rdata, img(32'hDA7A0000, 32'h10));
    chk("R7 no error flag", 32'(map_err), 0);
  endtask

  task automatic t_char;
    access(32'h80000, 32'h12345648, 4'hF);
    chk("R8 strobe with ready", {31'b0, c_cv & c_rdy}, 1);
    chk("R8 char byte", 32'(c_cd), 32'h48);
    chk("R8 strobe one cycle", 32'(c_cv_post), 0);
    chk("R10 char store rdata", c_rdata, 0);
    access(32'h80000, 32'h00000069, 4'h1);
    chk("R8 second strobe", 32'(c_cv), 1);
    chk("R8 second byte", 32'(c_cd), 32'h69);
    access(32'h80000, 0, 4'h0);
    chk("R8 read gives zero", c_rdata, 0);
    chk("R8 read no strobe", 32'(c_cv), 0);
    chk("R8 read acked", 32'(c_rdy), 1);
  endtask

  task automatic t_store_rdata;
    access(32'h40020, 32'hFFFFFFFF, 4'hF);
    chk("R10 ram store rdata", c_rdata, 0);
  endtask

  task automatic t_unmapped;
    access(32'h80004, 0, 4'h0);
    chk("R9 unmapped acked", 32'(c_rdy), 1);
    chk("R9 unmapped reads zero", c_rdata, 0);
    chk("R9 error set", 32'(map_err), 1);
    access(32'h40000, 0, 4'h0);
    chk("R9 error sticky", 32'(map_err), 1);
    chk("R9 later access ok", c_rdata, 32'hCAFE0001);
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_code();
    t_dinit();
    t_ram();
    t_lanes();
    t_rom_store();
    t_char();
    t_store_rdata();
    t_unmapped();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule